// File: doc/BRIEF.md
# Validation Event Scheduler

This block lets a validation test arrange for a reset, an interrupt, a fast interrupt or an external debug request to arrive a chosen number of clock cycles in the future. Three 32-bit counters are shared with the performance monitor and schedule reset, interrupt and fast interrupt. A separate 6-bit counter, which the performance monitor never touches, schedules debug requests. Each counter counts upward, and its event fires when it rolls over from all ones to zero.

A test loads a counter with the two's complement of the wanted delay. It then issues an operation with a 2-bit group code and a 3-bit selection mask. That operation starts or stops any combination of the three shared counters, or the debug counter alone. Each event leaves the block as a one-cycle pulse that the core cannot tell apart from an ordinary external event.

Access is limited to secure privileged requests unless a grant bit allows user and non-secure requests. A refused or malformed request raises a one-cycle trap and changes nothing. While the performance monitor owns the counters, the scheduler is inert.

Top module: `val_event_sched`

## Requirements
- R1: After reset, all four counters are idle, no event or trap is asserted, the grant bit is clear and all counts are zero.
- R2: A counter loaded with 0 - N and then started produces exactly one event pulse, one cycle wide, in the N-th cycle after the start takes effect. The pulse appears on `evt_reset_o` for index 0, `evt_irq_o` for index 1, `evt_fiq_o` for index 2 and `evt_dbg_o` for index 3.
- R3: An operation with group code 0 and a non-zero mask starts every shared counter whose mask bit is set. Mask bit 0 selects reset, bit 1 selects interrupt and bit 2 selects fast interrupt. `running_o` bits [0..3] follow the order reset, interrupt, fast interrupt, debug.
- R4: Group code 1 with mask 0 starts the debug counter. That counter keeps only the low 6 bits of a loaded value and counts modulo 64.
- R5: Group code 2 with a non-zero mask stops the selected shared counters. A stopped counter keeps its count, and restarting it resumes from that count.
- R6: Group code 3 with mask 0 stops the debug counter.
- R7: After its event fires, a counter is idle with a count of zero. Restarting it without a new load fires after 2^W cycles, which is 64 for the debug counter.
- R8: Load, clear and operation requests are accepted only when `secure_i` and `priv_i` are both high, or when the grant bit is set. A refused request asserts `trap_o` in the following cycle and has no effect.
- R9: Only a secure privileged request may write the grant bit through `ctl_wr_i`. Any other write traps and leaves the bit unchanged.
- R10: Group codes 0 and 2 with mask 0 trap. Group codes 1 and 3 with a non-zero mask trap. Neither case has any effect.
- R11: While `pmu_owns_i` is high, every counter is held idle, no event fires and every load, clear and operation request traps.
- R12: A clear request stops all four counters and sets their counts to zero.
- R13: A stop that arrives in the same cycle a counter would roll over suppresses the event. The counter is left idle at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| secure_i | input | 1 | Requester is in the secure state |
| priv_i | input | 1 | Requester is privileged |
| pmu_owns_i | input | 1 | Performance monitor currently owns the shared counters |
| ctl_wr_i | input | 1 | Write strobe for the grant bit |
| ctl_grant_i | input | 1 | New grant bit value |
| load_i | input | 1 | Load strobe |
| load_sel_i | input | 2 | Counter to load (0 reset, 1 interrupt, 2 fast interrupt, 3 debug) |
| load_val_i | input | CNT_W | Load value; the debug counter uses the low DBG_W bits |
| clear_i | input | 1 | Clear strobe: stop all counters and zero their counts |
| op_i | input | 1 | Operation strobe |
| op_code_i | input | 2 | Group code: 0 start shared, 1 start debug, 2 stop shared, 3 stop debug |
| op_mask_i | input | 3 | Selection mask for the shared counters |
| running_o | output | 4 | Per-counter running flags |
| evt_reset_o | output | 1 | Scheduled reset pulse |
| evt_irq_o | output | 1 | Scheduled interrupt pulse |
| evt_fiq_o | output | 1 | Scheduled fast interrupt pulse |
| evt_dbg_o | output | 1 | Scheduled debug request pulse |
| trap_o | output | 1 | Refused or malformed request, one cycle after it |

## Verification
The hardest case to reach is a stop that arrives in the very cycle a counter would roll over. The stimulus loads a delay of two and issues the stop immediately after the start. The stop therefore meets the counter exactly at all ones. The bench then confirms that no pulse follows and that a later restart fires after one cycle. Pause-and-resume timing, the debug counter's 64-cycle wrap after a fire or a clear, and the handover to the performance monitor in the middle of a count are all reached by counting negative edges from a known start.

// File: rtl/vsched_pkg.sv
package vsched_pkg;
  localparam int NUM_EVT  = 4;
  localparam int NUM_MAIN = 3;

  typedef enum logic [1:0] {
    EV_RESET = 2'd0,
    EV_IRQ   = 2'd1,
    EV_FIQ   = 2'd2,
    EV_DBG   = 2'd3
  } ev_e;

  typedef enum logic [1:0] {
    OP_START_MAIN = 2'd0,
    OP_START_DBG  = 2'd1,
    OP_STOP_MAIN  = 2'd2,
    OP_STOP_DBG   = 2'd3
  } op_e;
endpackage

// File: rtl/vsched_access.sv
module vsched_access
  import vsched_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                secure_i,
  input  logic                priv_i,
  input  logic                pmu_owns_i,
  input  logic                ctl_wr_i,
  input  logic                ctl_grant_i,
  input  logic                load_i,
  input  logic [1:0]          load_sel_i,
  input  logic                clear_i,
  input  logic                op_i,
  input  logic [1:0]          op_code_i,
  input  logic [NUM_MAIN-1:0] op_mask_i,
  output logic [NUM_EVT-1:0]  load_vec_o,
  output logic [NUM_EVT-1:0]  start_vec_o,
  output logic [NUM_EVT-1:0]  stop_vec_o,
  output logic                clear_o,
  output logic                grant_o,
  output logic                trap_o
);
  logic grant_q, trap_q;
  logic sec_priv, allowed, op_legal, op_ok, load_ok, clear_ok, ctl_ok;
  logic mask_any;

  assign sec_priv = secure_i & priv_i;
  assign allowed  = ~pmu_owns_i & (sec_priv | grant_q);
  assign mask_any = |op_mask_i;

  always_comb begin
    unique case (op_code_i)
      OP_START_MAIN, OP_STOP_MAIN: op_legal = mask_any;
      default:                     op_legal = ~mask_any;
    endcase
  end

  assign op_ok    = op_i & allowed & op_legal;
  assign load_ok  = load_i & allowed;
  assign clear_ok = clear_i & allowed;
  assign ctl_ok   = ctl_wr_i & sec_priv;

  always_comb begin
    start_vec_o = '0;
    stop_vec_o  = '0;
    if (op_ok) begin
      unique case (op_code_i)
        OP_START_MAIN: start_vec_o = {1'b0, op_mask_i};
        OP_START_DBG:  start_vec_o[EV_DBG] = 1'b1;
        OP_STOP_MAIN:  stop_vec_o  = {1'b0, op_mask_i};
        default:       stop_vec_o[EV_DBG] = 1'b1;
      endcase
    end
  end

  assign load_vec_o = load_ok ? (NUM_EVT'(1) << load_sel_i) : '0;
  assign clear_o    = clear_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= 1'b0;
      trap_q  <= 1'b0;
    end else begin
      if (ctl_ok) grant_q <= ctl_grant_i;
      trap_q <= (op_i & ~op_ok) | (load_i & ~load_ok) |
                (clear_i & ~clear_ok) | (ctl_wr_i & ~ctl_ok);
    end
  end

  assign grant_o = grant_q;
  assign trap_o  = trap_q;
endmodule

// File: rtl/vsched_counter.sv
module vsched_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         halt_i,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         start_i,
  input  logic         stop_i,
  output logic         running_o,
  output logic         event_o
);
  logic [W-1:0] cnt_q;
  logic         run_q, evt_q;
  logic         at_max;

  assign at_max = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      evt_q <= 1'b0;
    end else if (halt_i || clear_i) begin
      run_q <= 1'b0;
      evt_q <= 1'b0;
      if (clear_i) cnt_q <= '0;
    end else begin
      // stop in the rollover cycle suppresses the event
      evt_q <= run_q & at_max & ~stop_i;
      if (load_i)              cnt_q <= load_val_i;
      else if (run_q && !stop_i) cnt_q <= cnt_q + 1'b1;
      if (stop_i)              run_q <= 1'b0;
      else if (run_q && at_max) run_q <= 1'b0;
      else if (start_i)        run_q <= 1'b1;
    end
  end

  assign running_o = run_q;
  assign event_o   = evt_q;
endmodule

// File: rtl/val_event_sched.sv
module val_event_sched
  import vsched_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DBG_W = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                secure_i,
  input  logic                priv_i,
  input  logic                pmu_owns_i,
  input  logic                ctl_wr_i,
  input  logic                ctl_grant_i,
  input  logic                load_i,
  input  logic [1:0]          load_sel_i,
  input  logic [CNT_W-1:0]    load_val_i,
  input  logic                clear_i,
  input  logic                op_i,
  input  logic [1:0]          op_code_i,
  input  logic [NUM_MAIN-1:0] op_mask_i,
  output logic [NUM_EVT-1:0]  running_o,
  output logic                evt_reset_o,
  output logic                evt_irq_o,
  output logic                evt_fiq_o,
  output logic                evt_dbg_o,
  output logic                trap_o
);
  logic [NUM_EVT-1:0] load_vec, start_vec, stop_vec, evt_vec;
  logic               clear_req, grant_q;

  vsched_access u_access (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .secure_i    (secure_i),
    .priv_i      (priv_i),
    .pmu_owns_i  (pmu_owns_i),
    .ctl_wr_i    (ctl_wr_i),
    .ctl_grant_i (ctl_grant_i),
    .load_i      (load_i),
    .load_sel_i  (load_sel_i),
    .clear_i     (clear_i),
    .op_i        (op_i),
    .op_code_i   (op_code_i),
    .op_mask_i   (op_mask_i),
    .load_vec_o  (load_vec),
    .start_vec_o (start_vec),
    .stop_vec_o  (stop_vec),
    .clear_o     (clear_req),
    .grant_o     (grant_q),
    .trap_o      (trap_o)
  );

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_cnt
    localparam int W = (i == int'(EV_DBG)) ? DBG_W : CNT_W;
    vsched_counter #(.W(W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .halt_i     (pmu_owns_i),
      .clear_i    (clear_req),
      .load_i     (load_vec[i]),
      .load_val_i (load_val_i[W-1:0]),
      .start_i    (start_vec[i]),
      .stop_i     (stop_vec[i]),
      .running_o  (running_o[i]),
      .event_o    (evt_vec[i])
    );
  end

  assign evt_reset_o = evt_vec[EV_RESET];
  assign evt_irq_o   = evt_vec[EV_IRQ];
  assign evt_fiq_o   = evt_vec[EV_FIQ];
  assign evt_dbg_o   = evt_vec[EV_DBG];
endmodule

// File: rtl/vsched_checker.sv
module vsched_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       secure_i,
  input logic       priv_i,
  input logic       pmu_owns_i,
  input logic       op_i,
  input logic [1:0] op_code_i,
  input logic [2:0] op_mask_i,
  input logic       grant_i,
  input logic [3:0] running_i,
  input logic [3:0] evt_i,
  input logic       trap_i
);
  AST_EVT_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((evt_i & $past(evt_i)) == 4'b0)); // R2

  AST_EVT_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i & ~$past(running_i)) == 4'b0); // R2

  AST_IDLE_AFTER_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i & running_i) == 4'b0); // R7

  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pmu_owns_i |=> (running_i == 4'b0 && evt_i == 4'b0)); // R11

  AST_USER_DENIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i && !(secure_i && priv_i) && !grant_i) |=> trap_i); // R8

  AST_STOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i && op_code_i == 2'd2 && secure_i && priv_i && !pmu_owns_i)
      |=> ((evt_i[2:0] & $past(op_mask_i)) == 3'b0 &&
           (running_i[2:0] & $past(op_mask_i)) == 3'b0)); // R13
endmodule

bind val_event_sched vsched_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .secure_i   (secure_i),
  .priv_i     (priv_i),
  .pmu_owns_i (pmu_owns_i),
  .op_i       (op_i),
  .op_code_i  (op_code_i),
  .op_mask_i  (op_mask_i),
  .grant_i    (grant_q),
  .running_i  (running_o),
  .evt_i      (evt_vec),
  .trap_i     (trap_o)
);

// File: tb/val_event_sched_bench.sv
`timescale 1ns/1ps
module val_event_sched_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        secure = 1'b1, priv = 1'b1, pmu_owns = 1'b0;
  logic        ctl_wr = 1'b0, ctl_grant = 1'b0;
  logic        load = 1'b0, clear = 1'b0, op = 1'b0;
  logic [1:0]  load_sel = 2'd0, op_code = 2'd0;
  logic [31:0] load_val = 32'd0;
  logic [2:0]  op_mask = 3'd0;
  logic [3:0]  running;
  logic        e_rst, e_irq, e_fiq, e_dbg, trap;
  logic [3:0]  evts;
  int checks = 0, failures = 0;
  int first_ev [4];
  int pulses [4];

  assign evts = {e_dbg, e_fiq, e_irq, e_rst};
  always #2 clk = ~clk;

  val_event_sched u_val_event_sched (
    .clk_i(clk), .rst_ni(rst_n), .secure_i(secure), .priv_i(priv),
    .pmu_owns_i(pmu_owns), .ctl_wr_i(ctl_wr), .ctl_grant_i(ctl_grant),
    .load_i(load), .load_sel_i(load_sel), .load_val_i(load_val),
    .clear_i(clear), .op_i(op), .op_code_i(op_code), .op_mask_i(op_mask),
    .running_o(running), .evt_reset_o(e_rst), .evt_irq_o(e_irq),
    .evt_fiq_o(e_fiq), .evt_dbg_o(e_dbg), .trap_o(trap)
  );

  typedef struct packed { logic [1:0] sel; logic [7:0] n; } vec_t;
  localparam vec_t VEC [8] = '{
    '{2'd0, 8'd1}, '{2'd0, 8'd5}, '{2'd1, 8'd2}, '{2'd1, 8'd37},
    '{2'd2, 8'd3}, '{2'd2, 8'd100}, '{2'd3, 8'd1}, '{2'd3, 8'd63}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [1:0] sel, input logic [31:0] v);
    @(negedge clk); load = 1'b1; load_sel = sel; load_val = v;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic do_op(input logic [1:0] code, input logic [2:0] mask);
    @(negedge clk); op = 1'b1; op_code = code; op_mask = mask;
    @(negedge clk); op = 1'b0; op_mask = 3'd0;
  endtask

  task automatic do_ctl(input logic g);
    @(negedge clk); ctl_wr = 1'b1; ctl_grant = g;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  task automatic watch(input int limit);
    for (int i = 0; i < 4; i++) begin first_ev[i] = 0; pulses[i] = 0; end
    for (int j = 1; j <= limit; j++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) if (evts[i]) begin
        pulses[i]++;
        if (first_ev[i] == 0) first_ev[i] = j;
      end
    end
  endtask

  task automatic start_one(input logic [1:0] sel);
    if (sel == 2'd3) do_op(2'd1, 3'd0);
    else do_op(2'd0, 3'(1 << sel));
  endtask

  initial begin
    #(200000 * 4);
    failures++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(running == 4'b0 && evts == 4'b0 && trap == 1'b0, "R1", {running, evts}, 0);
    rst_n = 1'b1;
    // R7/R1 counts zero after reset: debug counter fires after 64
    start_one(2'd3);
    watch(70);
    chk(first_ev[3] == 64, "R1", first_ev[3], 64);

    // R2 table walk
    foreach (VEC[k]) begin
      do_load(VEC[k].sel, 32'd0 - 32'(VEC[k].n));
      start_one(VEC[k].sel);
      watch(110);
      chk(first_ev[VEC[k].sel] == int'(VEC[k].n), "R2", first_ev[VEC[k].sel], VEC[k].n);
      chk(pulses[VEC[k].sel] == 1, "R2", pulses[VEC[k].sel], 1);
      chk(running == 4'b0, "R7", running, 0);
    end

    // R3 combined start
    do_load(2'd0, -32'd4); do_load(2'd1, -32'd6); do_load(2'd2, -32'd8);
    do_op(2'd0, 3'b111);
    chk(running == 4'b0111, "R3", running, 7);
    watch(12);
    chk(first_ev[0] == 4 && first_ev[1] == 6 && first_ev[2] == 8, "R3",
        first_ev[0] * 10000 + first_ev[1] * 100 + first_ev[2], 40608);
    chk(first_ev[3] == 0, "R3", first_ev[3], 0);

    // R3/R5 partial start and partial stop
    do_load(2'd0, -32'd50); do_load(2'd2, -32'd50);
    do_op(2'd0, 3'b101);
    chk(running == 4'b0101, "R3", running, 5);
    do_op(2'd2, 3'b001);
    chk(running == 4'b0100, "R5", running, 4);
    do_op(2'd2, 3'b100);
    chk(running == 4'b0000, "R5", running, 0);

    // R5 pause and resume keeps count
    do_load(2'd1, -32'd10);
    do_op(2'd0, 3'b010);
    watch(3);
    do_op(2'd2, 3'b010);
    watch(5);
    chk(pulses[1] == 0 && running[1] == 1'b0, "R5", pulses[1], 0);
    do_op(2'd0, 3'b010);
    watch(10);
    chk(first_ev[1] == 6, "R5", first_ev[1], 6);

    // R4 debug keeps low 6 bits: 0x0FFD -> 0x3D -> 3 cycles
    do_load(2'd3, 32'h0000_0FFD);
    start_one(2'd3);
    watch(8);
    chk(first_ev[3] == 3, "R4", first_ev[3], 3);
    // R7 restart without load after a fire wraps fully
    start_one(2'd3);
    watch(70);
    chk(first_ev[3] == 64, "R7", first_ev[3], 64);

    // R6 stop debug
    do_load(2'd3, -32'd30);
    start_one(2'd3);
    do_op(2'd3, 3'd0);
    chk(running[3] == 1'b0, "R6", running, 0);
    watch(40);
    chk(pulses[3] == 0, "R6", pulses[3], 0);

    // R13 stop meets rollover
    do_load(2'd2, -32'd2);
    do_op(2'd0, 3'b100);
    do_op(2'd2, 3'b100);
    watch(6);
    chk(pulses[2] == 0 && running[2] == 1'b0, "R13", pulses[2], 0);
    do_op(2'd0, 3'b100);
    watch(4);
    chk(first_ev[2] == 1, "R13", first_ev[2], 1);

    // R10 malformed operations
    do_op(2'd0, 3'd0);
    chk(trap == 1'b1 && running == 4'b0, "R10", {trap, running}, 16);
    do_op(2'd1, 3'd2);
    chk(trap == 1'b1 && running == 4'b0, "R10", {trap, running}, 16);
    do_op(2'd2, 3'd0);
    chk(trap == 1'b1, "R10", trap, 1);

    // R8 user and non-secure denied without grant
    do_load(2'd0, -32'd3);
    secure = 1'b1; priv = 1'b0;
    do_op(2'd0, 3'b001);
    chk(trap == 1'b1 && running == 4'b0, "R8", {trap, running}, 16);
    secure = 1'b0; priv = 1'b1;
    do_op(2'd0, 3'b001);
    chk(trap == 1'b1 && running == 4'b0, "R8", {trap, running}, 16);
    // R9 grant write refused from non-secure
    do_ctl(1'b1);
    chk(trap == 1'b1, "R9", trap, 1);
    do_op(2'd0, 3'b001);
    chk(running == 4'b0, "R9", running, 0);
    secure = 1'b1; priv = 1'b1;
    do_ctl(1'b1);
    chk(trap == 1'b0, "R9", trap, 0);
    secure = 1'b0; priv = 1'b0;
    do_op(2'd0, 3'b001);
    chk(trap == 1'b0 && running == 4'b0001, "R8", {trap, running}, 1);
    watch(5);
    chk(first_ev[0] == 3, "R8", first_ev[0], 3);
    do_ctl(1'b0);
    chk(trap == 1'b1, "R9", trap, 1);
    do_op(2'd1, 3'd0);
    chk(running[3] == 1'b1, "R9", running, 8);
    do_op(2'd3, 3'd0);
    secure = 1'b1; priv = 1'b1;
    do_ctl(1'b0);

    // R11 performance monitor owns the counters
    do_load(2'd1, -32'd20);
    do_op(2'd0, 3'b010);
    @(negedge clk); pmu_owns = 1'b1;
    @(negedge clk);
    chk(running == 4'b0, "R11", running, 0);
    watch(30);
    chk(pulses[1] == 0, "R11", pulses[1], 0);
    do_op(2'd0, 3'b010);
    chk(trap == 1'b1 && running == 4'b0, "R11", {trap, running}, 16);
    pmu_owns = 1'b0;

    // R12 clear stops all and zeroes counts
    do_load(2'd3, -32'd10);
    start_one(2'd3);
    do_load(2'd0, -32'd40);
    do_op(2'd0, 3'b001);
    do_clear();
    chk(running == 4'b0, "R12", running, 0);
    start_one(2'd3);
    watch(70);
    chk(first_ev[3] == 64, "R12", first_ev[3], 64);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule